// File: doc/BRIEF.md
# Frame-Gated Serial Control Port

This block is the device side of a three-wire control link for a voice-processing engine. It runs from the system clock and drives an active-low frame-ready output. That output opens one transfer window in every sample frame: 2560 clock cycles at a 20.48 MHz clock, which is an 8 kHz frame rate. Inside an open window, the host clocks one 16-bit control word into the block, one bit on each rising edge of its strobe line. The word carries a register number and a payload, and the payload lands in one of six control registers. The register outputs feed the processing engine.

The strobe and data lines are asynchronous to the system clock. Both pass through a two-flop synchronizer, and a rising edge on the strobe is found by comparing its synchronized value with the value one cycle earlier. After reset, the host must complete a handshake before any write is accepted: four strobe pulses, counted by the block, that carry no data. If a window closes before all sixteen bits have arrived, the partial word is thrown away.

Top module: `ctl_serial_port`

## Requirements
- R1: `frame_rdy_n_o` goes low once every FRAME_CYCLES clock cycles. It stays low for WINDOW_CYCLES cycles and is high for the remainder of the frame.
- R2: While `rst` is high, and on the first cycle after it is released, every register field reads zero, `ready_o` is 0, `bad_idx_o` is 0 and `frame_rdy_n_o` is 1.
- R3: After reset, the first four strobe rising edges are counted as a handshake and shift no data, whether or not a window is open. `ready_o` rises after the fourth edge and stays high until the next reset. No register changes while `ready_o` is low.
- R4: When `ready_o` is high, the sixteen strobe rising edges inside one open window shift in a word, most significant bit first. Bits 15:13 form the register number and bits 12:0 form the payload. The payload is written to register k, which appears on `reg_flat_o[13k+12:13k]`, within four cycles of the sixteenth edge.
- R5: A word whose register number is 6 or 7 changes no register and pulses `bad_idx_o` high for exactly one cycle.
- R6: If a window closes after fewer than sixteen edges of a word, those bits are dropped. The next window starts a fresh word.
- R7: Strobe rising edges that occur while `frame_rdy_n_o` is high (after the handshake) shift no data and leave the registers unchanged.
- R8: A write changes only the register it addresses. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Host bit clock, asynchronous |
| data_i | input | 1 | Host serial data, sampled on strobe rising edge |
| frame_rdy_n_o | output | 1 | Active-low transfer window, once per frame |
| ready_o | output | 1 | Reset handshake complete |
| bad_idx_o | output | 1 | One-cycle pulse on an unused register number |
| reg_flat_o | output | 78 | Six 13-bit control registers, register k at bits 13k+12:13k |

## Verification
The checks assume that each strobe level lasts at least three system clocks and that data is stable for the whole high phase of the strobe. Without that, the synchronizer could miss edges and the handshake and bit counts would drift. The stimulus changes data only together with the falling edge of the strobe, holds each level for three cycles, and starts a word only after it has seen the window open. Every sixteen-bit word therefore ends well before the window closes. Partial words and strobes outside a window are produced on purpose, so that the drop rules are exercised.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int CSP_FRAME_CYCLES  = 2560;
  localparam int CSP_WINDOW_CYCLES = 1280;
  localparam int CSP_WORD_W        = 16;
  localparam int CSP_IDX_W         = 3;
  localparam int CSP_NUM_REGS      = 6;
  localparam int CSP_HS_PULSES     = 4;
  localparam int CSP_SYNC_STAGES   = 2;

  typedef enum logic {HS_WAIT = 1'b0, HS_DONE = 1'b1} hs_state_t;
endpackage

// File: rtl/csp_frame_timer.sv
module csp_frame_timer #(
  parameter int FRAME_CYCLES  = 2560,
  parameter int WINDOW_CYCLES = 1280
) (
  input  logic clk,
  input  logic rst,
  output logic frame_rdy_n_o,
  output logic win_o
);
  localparam int CNT_W = $clog2(FRAME_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q == CNT_W'(FRAME_CYCLES - 1)) cnt_nxt = '0;
    else                                    cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= CNT_W'(FRAME_CYCLES - 1);
      frame_rdy_n_o <= 1'b1;
    end else begin
      cnt_q         <= cnt_nxt;
      frame_rdy_n_o <= (cnt_nxt >= CNT_W'(WINDOW_CYCLES));
    end
  end

  assign win_o = ~frame_rdy_n_o;
endmodule

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/csp_shifter.sv
module csp_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_i,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int BC_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [BC_W-1:0]   bc_q;
  logic [WORD_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      bc_q       <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (!win_i) begin
        bc_q <= '0;
      end else if (rise_i && en_i) begin
        sh_q <= sh_nxt;
        if (bc_q == BC_W'(WORD_W - 1)) begin
          bc_q       <= '0;
          word_vld_o <= 1'b1;
          word_o     <= sh_nxt;
        end else begin
          bc_q <= bc_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csp_regbank.sv
module csp_regbank #(
  parameter int WORD_W   = 16,
  parameter int IDX_W    = 3,
  parameter int NUM_REGS = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_i,
  input  logic [WORD_W-1:0]                 word_i,
  output logic                              bad_idx_o,
  output logic [NUM_REGS*(WORD_W-IDX_W)-1:0] reg_flat_o
);
  localparam int PW = WORD_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [PW-1:0]    payload;
  logic             idx_ok;

  assign idx     = word_i[WORD_W-1 -: IDX_W];
  assign payload = word_i[PW-1:0];
  assign idx_ok  = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) bad_idx_o <= 1'b0;
    else     bad_idx_o <= wr_i && !idx_ok;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [PW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)                                   r_q <= '0;
      else if (wr_i && idx == IDX_W'(i))         r_q <= payload;
    end
    assign reg_flat_o[i*PW +: PW] = r_q;
  end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import csp_pkg::*;
#(
  parameter int FRAME_CYCLES  = CSP_FRAME_CYCLES,
  parameter int WINDOW_CYCLES = CSP_WINDOW_CYCLES,
  parameter int WORD_W        = CSP_WORD_W,
  parameter int IDX_W         = CSP_IDX_W,
  parameter int NUM_REGS      = CSP_NUM_REGS,
  parameter int HS_PULSES     = CSP_HS_PULSES,
  parameter int SYNC_STAGES   = CSP_SYNC_STAGES
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                strobe_i,
  input  logic                                data_i,
  output logic                                frame_rdy_n_o,
  output logic                                ready_o,
  output logic                                bad_idx_o,
  output logic [NUM_REGS*(WORD_W-IDX_W)-1:0]  reg_flat_o
);
  localparam int HS_W = $clog2(HS_PULSES + 1);

  logic              win;
  logic [1:0]        sync_q;
  logic              strb_s, data_s, strb_prev, rise;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  hs_state_t         hs_q;
  logic [HS_W-1:0]   hs_cnt_q;

  csp_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .frame_rdy_n_o(frame_rdy_n_o), .win_o(win));

  csp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({strobe_i, data_i}), .q_o(sync_q));

  assign strb_s = sync_q[1];
  assign data_s = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) strb_prev <= 1'b0;
    else     strb_prev <= strb_s;
  end
  assign rise = strb_s & ~strb_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= HS_WAIT;
      hs_cnt_q <= '0;
    end else if (hs_q == HS_WAIT && rise) begin
      if (hs_cnt_q == HS_W'(HS_PULSES - 1)) hs_q <= HS_DONE;
      else                                  hs_cnt_q <= hs_cnt_q + 1'b1;
    end
  end
  assign ready_o = (hs_q == HS_DONE);

  csp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .win_i(win), .en_i(ready_o), .rise_i(rise),
    .bit_i(data_s), .word_vld_o(word_vld), .word_o(word));

  csp_regbank #(.WORD_W(WORD_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .wr_i(word_vld), .word_i(word),
    .bad_idx_o(bad_idx_o), .reg_flat_o(reg_flat_o));
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk #(
  parameter int FRAME_CYCLES = 2560,
  parameter int RW           = 78
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_rdy_n_o,
  input logic          ready_o,
  input logic          bad_idx_o,
  input logic [RW-1:0] reg_flat_o
);
  localparam int GW = $clog2(FRAME_CYCLES + 1);

  logic          prev_rdy, seen_fall, fall;
  logic [GW-1:0] gap;

  assign fall = prev_rdy && !frame_rdy_n_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rdy  <= 1'b1;
      seen_fall <= 1'b0;
      gap       <= '0;
    end else begin
      prev_rdy <= frame_rdy_n_o;
      if (fall) begin
        seen_fall <= 1'b1;
        gap       <= '0;
      end else if (gap != GW'(FRAME_CYCLES)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (fall && seen_fall) |-> (gap == GW'(FRAME_CYCLES - 1))); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_flat_o == '0 && !ready_o && !bad_idx_o)); // R2

  AST_NO_WRITE_UNREADY: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> $stable(reg_flat_o)); // R3

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o); // R3

  AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bad_idx_o |=> !bad_idx_o); // R5

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    bad_idx_o |-> $stable(reg_flat_o)); // R5
endmodule

bind ctl_serial_port ctl_serial_port_chk #(
  .FRAME_CYCLES(FRAME_CYCLES),
  .RW(NUM_REGS*(WORD_W-IDX_W))
) u_chk (
  .clk(clk), .rst(rst), .frame_rdy_n_o(frame_rdy_n_o), .ready_o(ready_o),
  .bad_idx_o(bad_idx_o), .reg_flat_o(reg_flat_o));

// File: tb/tb_ctl_serial_port.sv
module tb_ctl_serial_port;
  localparam int F  = 256;
  localparam int W  = 160;
  localparam int NR = 6;
  localparam int PW = 13;
  localparam int RW = NR*PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic data = 1'b0;
  logic rdy_n, ready, bad;
  logic [RW-1:0] regs;

  int n_chk = 0, n_bad = 0, bad_seen = 0;
  bit done = 1'b0;
  logic [PW-1:0] model [NR];

  always #2 clk = ~clk;

  ctl_serial_port #(.FRAME_CYCLES(F), .WINDOW_CYCLES(W)) dut (
    .clk(clk), .rst(rst), .strobe_i(strobe), .data_i(data),
    .frame_rdy_n_o(rdy_n), .ready_o(ready), .bad_idx_o(bad), .reg_flat_o(regs));

  always @(negedge clk) if (bad) bad_seen++;

  // {expected bad flag, word}
  localparam logic [16:0] VEC [10] = '{
    17'h01ABC, 17'h02555, 17'h05FFF, 17'h06001, 17'h09000,
    17'h0AAAA, 17'h1C123, 17'h1FFFF, 17'h00000, 17'h0B357};

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] model_flat();
    logic [RW-1:0] f;
    for (int i = 0; i < NR; i++) f[i*PW +: PW] = model[i];
    return f;
  endfunction

  task automatic pulse(input logic b);
    @(negedge clk); data = b; strobe = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_open();
    @(negedge clk);
    while (!rdy_n) @(negedge clk);
    while (rdy_n)  @(negedge clk);
  endtask

  task automatic wait_close();
    while (!rdy_n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int nb);
    wait_open();
    for (int i = 15; i >= 16 - nb; i--) pulse(w[i]);
    wait_close();
    repeat (4) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(regs, '0, "R2 regs in reset");
    chk(ready, 1'b0, "R2 ready in reset");
    chk(bad, 1'b0, "R2 bad in reset");
    chk(rdy_n, 1'b1, "R2 frame_rdy_n in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(regs, '0, "R2 regs after release");
    for (int i = 0; i < NR; i++) model[i] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t_fall, t_rise, t_fall2, b0;
    apply_reset();

    // R1: frame period and window length
    wait_open(); t_fall = 0;
    while (!rdy_n) begin @(negedge clk); t_fall++; end
    t_rise = t_fall;
    while (rdy_n) begin @(negedge clk); t_rise++; end
    t_fall2 = t_rise;
    chk(t_fall, W, "R1 window length");
    chk(t_fall2, F, "R1 frame period");

    // R3: handshake
    for (int i = 0; i < 3; i++) pulse(1'b1);
    repeat (5) @(negedge clk);
    chk(ready, 1'b0, "R3 not ready after three pulses");
    pulse(1'b0);
    repeat (5) @(negedge clk);
    chk(ready, 1'b1, "R3 ready after fourth pulse");
    chk(regs, '0, "R3 handshake writes nothing");

    // R4 R5 R8: vector table
    for (int v = 0; v < 10; v++) begin
      logic [15:0] w;
      w = VEC[v][15:0];
      b0 = bad_seen;
      send_bits(w, 16);
      if (w[15:13] < 3'd6) model[w[15:13]] = w[12:0];
      chk(regs, model_flat(), $sformatf("R4 R8 regs after word %0h", w));
      chk(bad_seen - b0, VEC[v][16] ? 1 : 0, "R5 bad pulse count");
    end

    // R6: partial word then full word
    send_bits(16'h2FFF, 10);
    chk(regs, model_flat(), "R6 partial word writes nothing");
    send_bits(16'h8ABC, 16);
    model[4] = 13'h0ABC;
    chk(regs, model_flat(), "R6 fresh word after drop");

    // R7: strobes while window closed
    wait_open(); wait_close();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    chk(rdy_n, 1'b1, "R7 pulses stayed outside window");
    chk(regs, model_flat(), "R7 closed-window strobes write nothing");
    send_bits(16'h2111, 16);
    model[1] = 13'h0111;
    chk(regs, model_flat(), "R7 next word aligned");

    // R2 R3: mid-run reset, then word consumed by handshake
    apply_reset();
    chk(ready, 1'b0, "R3 ready cleared by reset");
    for (int i = 0; i < 3; i++) pulse(1'b0);
    send_bits(16'h4321, 16);
    chk(ready, 1'b1, "R3 ready after first bit completes handshake");
    chk(regs, '0, "R3 short remainder dropped");
    send_bits(16'h6ABC, 16);
    model[3] = 13'h0ABC;
    chk(regs, model_flat(), "R4 write after second handshake");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule